// File: doc/BRIEF.md
# NAND Host Command Sequencer

This block is the host side of a multiplexed NAND flash bus. It carries out one operation per start request as a string of bus cycles. First comes a single command latch cycle. Then come zero to five address latch cycles, and last an optional run of write-data or read-data cycles. It owns the chip-enable, the command-latch and address-latch levels, the write and read strobes and the shared I/O lines. It also watches the ready/busy line, which it passes through a two-flop synchronizer.

A request brings an opcode, a 40-bit address, an address-cycle count, a data length in bus words and a direction. It also brings the low and high widths of the strobe pulses, counted in clock cycles. Write words are taken from a valid/ready stream, and read words are handed out with a one-cycle valid. A one-cycle `done` marks the end of every operation. Chip-enable stays high whenever no operation is on the bus, so other devices can share the bus.

Top module: `nand_seq_top`

## Requirements
- R1: `nand_ce_n` is high while the block is idle and while it waits for ready, and low for every command, address and data strobe.
- R2: The command cycle drives `nand_cle`=1 and `nand_ale`=0 and places the opcode on `nand_io_out[7:0]`. One write-strobe pulse is issued, and the opcode is valid when `nand_we_n` rises.
- R3: Address cycles drive `nand_ale`=1 and `nand_cle`=0, each with one write-strobe pulse. Address cycle i carries bits [8i+7:8i] of `op_addr`, least significant byte first. The count is `op_naddr`, where 0 means none and any value above 5 is treated as 5.
- R4: With a 16-bit bus, `nand_io_out[15:8]` is zero during command and address cycles.
- R5: The phases always come in order: the command, then all address cycles, then all data cycles.
- R6: Opcodes 8'h70 and 8'hFF start at once even while `nand_rb_n` is low. Any other opcode keeps chip-enable high and issues no strobe until the synchronized `nand_rb_n` is high.
- R7: Every write or read strobe is low for exactly max(2, `op_t_lo`) clocks. Between strobes of one operation, the strobe is high for at least max(2, `op_t_hi`) clocks.
- R8: With `op_write`=1, `op_len` words are taken from the write stream on `wr_valid && wr_ready` and driven in order on write strobes with `nand_cle`=`nand_ale`=0. A word that is not yet valid delays its strobe.
- R9: With `op_write`=0, `op_len` read strobes are issued. `nand_io_in` is sampled on the clock edge at which `nand_re_n` rises, and each word appears on `rd_data` with `rd_valid` high for one cycle, in order.
- R10: `done` is high for exactly one cycle per operation, after the last strobe, with chip-enable already high. A zero address count and a zero length skip those phases.
- R11: `start` is ignored while the block is not idle: it adds no bus cycles and does not change the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op_code | input | 8 | Command opcode |
| op_addr | input | 40 | Address bytes, byte 0 sent first |
| op_naddr | input | 3 | Address cycle count (0..5, larger values clamp to 5) |
| op_len | input | 12 | Data words to transfer |
| op_write | input | 1 | 1 = write data phase, 0 = read data phase |
| op_t_lo | input | 4 | Strobe low width in clocks (minimum 2) |
| op_t_hi | input | 4 | Strobe high width in clocks (minimum 2) |
| idle | output | 1 | Block is ready for a start |
| done | output | 1 | One-cycle end-of-operation pulse |
| wr_data | input | 16 | Write stream word |
| wr_valid | input | 1 | Write stream word valid |
| wr_ready | output | 1 | Write stream word accepted this cycle if valid |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | Read word valid (one cycle) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 16 | Bus output value |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 16 | Bus input value |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the target |

## Verification
The bench aims at the busy wait. A design that ignored ready/busy would pull chip-enable low and pulse the strobe while the target is busy. A design that applied the wait to status or reset would hang with ready held low. The bench uses address counts of 0 and of 6 or 7, where an off-by-one shows up as a missing or extra address cycle, or as bytes sent most significant first. It also uses pulse widths of 0 and 1, where a missing clamp gives one-cycle strobes, and write streams with gaps, where a design that strobes before the word arrives latches stale data. A start pulse in the middle of an operation shows up as extra command cycles if the design does not block it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_CMD, S_ADDR, S_WDAT, S_RDAT, S_FIN
  } seq_st_t;

  typedef enum logic [1:0] {
    P_SETUP, P_LOAD, P_LOW, P_HIGH
  } phase_t;

  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  // Opcodes that may be issued while the target reports busy
  function automatic logic skips_ready(input logic [7:0] op);
    return (op == OP_STATUS) || (op == OP_RESET);
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_raw,
  output logic rb_ok
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], rb_raw};
  end

  assign rb_ok = sh[STAGES-1];
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          load_first,
  input  logic          load_ok,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  output phase_t        ph,
  output logic          lo_last,
  output logic          cyc_end
);
  logic [TW-1:0] cnt;

  assign lo_last = (ph == P_LOW)  && (cnt == t_lo - 1'b1);
  assign cyc_end = (ph == P_HIGH) && (cnt == t_hi - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= P_SETUP;
      cnt <= '0;
    end else if (!go) begin
      ph  <= P_SETUP;
      cnt <= '0;
    end else begin
      case (ph)
        P_SETUP: begin
          ph  <= load_first ? P_LOAD : P_LOW;
          cnt <= '0;
        end
        P_LOAD: if (load_ok) ph <= P_LOW;
        P_LOW: begin
          if (lo_last) begin
            ph  <= P_HIGH;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cyc_end) begin
            ph  <= P_SETUP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R7: once the strobe phase starts it lasts at least two clocks
  a_r7_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph == P_LOW) |=> (ph == P_LOW));
  a_r7_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ph == P_HIGH) && go) |=> (ph == P_HIGH));
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int LEN_W  = 12,
  parameter int TW     = 4,
  parameter int ADDR_W = 40,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [2:0]        op_naddr,
  input  logic [LEN_W-1:0]  op_len,
  input  logic              op_write,
  input  logic [TW-1:0]     op_t_lo,
  input  logic [TW-1:0]     op_t_hi,
  output logic              idle,
  output logic              done,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BUS_W-1:0]  nand_io_out,
  output logic              nand_io_oe,
  input  logic [BUS_W-1:0]  nand_io_in,
  input  logic              nand_rb_n
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  function automatic logic [TW-1:0] clamp_w(input logic [TW-1:0] w);
    return (w < TW'(2)) ? TW'(2) : w;
  endfunction

  function automatic logic [2:0] clamp_na(input logic [2:0] n);
    return (n > 3'(ADDR_BYTES)) ? 3'(ADDR_BYTES) : n;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a,
                                           input logic [LEN_W-1:0] i);
    return 8'(a >> {i, 3'b000});
  endfunction

  seq_st_t           st;
  logic [7:0]        r_code;
  logic [ADDR_W-1:0] r_addr;
  logic [2:0]        r_naddr;
  logic [LEN_W-1:0]  r_len;
  logic              r_wr;
  logic [TW-1:0]     r_tlo, r_thi;
  logic [LEN_W-1:0]  idx;
  logic [BUS_W-1:0]  wbuf;

  phase_t ph;
  logic   lo_last, cyc_end, go, rb_ok, take_word;
  seq_st_t data_st, after_cmd;
  logic    last_addr, last_data;

  nand_rb_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .rb_raw(nand_rb_n), .rb_ok(rb_ok));

  assign go = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT) || (st == S_RDAT);

  nand_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go),
    .load_first(st == S_WDAT), .load_ok(wr_valid),
    .t_lo(r_tlo), .t_hi(r_thi),
    .ph(ph), .lo_last(lo_last), .cyc_end(cyc_end));

  assign data_st   = (r_len == '0) ? S_FIN : (r_wr ? S_WDAT : S_RDAT);
  assign after_cmd = (r_naddr != 3'd0) ? S_ADDR : data_st;
  assign last_addr = (idx == LEN_W'(r_naddr) - 1'b1);
  assign last_data = (idx == r_len - 1'b1);
  assign take_word = wr_ready && wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; r_code <= '0; r_addr <= '0; r_naddr <= '0; r_len <= '0;
      r_wr <= 1'b0; r_tlo <= TW'(2); r_thi <= TW'(2); idx <= '0; wbuf <= '0;
    end else begin
      if (take_word) wbuf <= wr_data;
      case (st)
        S_IDLE: if (start) begin
          r_code  <= op_code;
          r_addr  <= op_addr;
          r_naddr <= clamp_na(op_naddr);
          r_len   <= op_len;
          r_wr    <= op_write;
          r_tlo   <= clamp_w(op_t_lo);
          r_thi   <= clamp_w(op_t_hi);
          idx     <= '0;
          st      <= skips_ready(op_code) ? S_CMD : S_WAIT;
        end
        S_WAIT: if (rb_ok) st <= S_CMD;
        S_CMD: if (cyc_end) begin
          st  <= after_cmd;
          idx <= '0;
        end
        S_ADDR: if (cyc_end) begin
          if (last_addr) begin
            st  <= data_st;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        S_WDAT, S_RDAT: if (cyc_end) begin
          if (last_data) st <= S_FIN;
          else           idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (st == S_RDAT) && lo_last;
      if ((st == S_RDAT) && lo_last) rd_data <= nand_io_in;
    end
  end

  always_comb begin
    case (st)
      S_CMD:   nand_io_out = BUS_W'(r_code);
      S_ADDR:  nand_io_out = BUS_W'(addr_byte(r_addr, idx));
      S_WDAT:  nand_io_out = wbuf;
      default: nand_io_out = '0;
    endcase
  end

  assign nand_ce_n  = !go;
  assign nand_cle   = (st == S_CMD);
  assign nand_ale   = (st == S_ADDR);
  assign nand_we_n  = !(go && (ph == P_LOW) && (st != S_RDAT));
  assign nand_re_n  = !((ph == P_LOW) && (st == S_RDAT));
  assign nand_io_oe = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT);
  assign wr_ready   = (st == S_WDAT) && (ph == P_LOAD);
  assign idle       = (st == S_IDLE);
  assign done       = (st == S_FIN);

  // R1: no chip-enable while idle
  a_r1_ce_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> nand_ce_n);
  // R2: a command strobe carries the latched opcode and no address latch
  a_r2_cmd_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && nand_cle) |-> (!nand_ale && nand_io_out[7:0] == r_code));
  // R6: leaving the wait state requires the synchronized ready
  a_r6_busy_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && $past(st) == S_WAIT) |-> $past(rb_ok));
  // R9: latch levels and read strobe never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nand_cle, nand_ale, !nand_re_n}));
  // R8: write and read strobes never both low
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R10: done lasts one cycle with chip-enable released
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nand_ce_n && nand_we_n && nand_re_n) ##1 !done);

  generate
    if (BUS_W > 8) begin : g_wide
      // R4: upper lines zero in command and address cycles
      a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> (nand_io_out[BUS_W-1:8] == '0));
    end
  endgenerate
endmodule

// File: tb/nand_seq_top_tb.sv
module nand_seq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  op_code = '0;
  logic [39:0] op_addr = '0;
  logic [2:0]  op_naddr = '0;
  logic [11:0] op_len = '0;
  logic        op_write = 1'b0;
  logic [3:0]  op_t_lo = '0, op_t_hi = '0;
  logic        idle, done, wr_ready, rd_valid;
  logic [15:0] wr_data = '0, rd_data;
  logic        wr_valid = 1'b0;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [15:0] nand_io_out, nand_io_in;
  logic        nand_rb_n = 1'b1;

  nand_seq_top u_dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wpat(input int k);
    return 16'h3C00 + 16'(k * 7);
  endfunction
  function automatic logic [15:0] rpat(input int k);
    return 16'hA500 ^ 16'(k * 16'h0137);
  endfunction
  function automatic int clampw(input int w);
    return (w < 2) ? 2 : w;
  endfunction

  // bus monitor state
  int ev_n = 0;
  int ev_kind [256];
  logic [15:0] ev_val [256];
  int rd_cnt = 0, rd_got = 0, done_cnt = 0;
  int exp_lo = 2, exp_hi = 2;
  int low_cnt = 0, hi_cnt = 0;
  bit prev_strobe = 1'b1, seen_strobe = 1'b0;

  assign nand_io_in = rpat(rd_cnt);

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        automatic bit s = nand_we_n && nand_re_n;
        if (!s) begin
          low_cnt++;
          if (prev_strobe && seen_strobe)
            check(hi_cnt >= exp_hi, "R7 high width", hi_cnt, exp_hi);
          check(!nand_ce_n, "R1 ce low on strobe", nand_ce_n, 0);
        end else hi_cnt++;
        if (!prev_strobe && s) begin
          check(low_cnt == exp_lo, "R7 low width", low_cnt, exp_lo);
          if (!nand_re_n || prev_strobe == 0 && nand_we_n && !nand_io_oe) rd_cnt++;
          else if (ev_n < 256) begin
            ev_kind[ev_n] = (nand_cle && !nand_ale) ? 0 : (nand_ale && !nand_cle) ? 1 :
                            (!nand_cle && !nand_ale) ? 2 : 3;
            ev_val[ev_n] = nand_io_out;
            ev_n++;
          end
          low_cnt = 0; hi_cnt = 0; seen_strobe = 1'b1;
        end
        if (s && prev_strobe) ; else if (!s) hi_cnt = 0;
        prev_strobe = s;
        if (rd_valid) begin
          check(rd_data == rpat(rd_got), "R9 read word", rd_data, rpat(rd_got));
          rd_got++;
        end
        if (done) begin
          done_cnt++;
          seen_strobe = 1'b0;
          check(nand_ce_n, "R10 ce high at done", nand_ce_n, 1);
        end
      end
    end
  end

  // write stream driver
  int wr_idx = 0;
  initial begin
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (pend) wr_idx++;
      wr_valid = ($urandom % 4) != 0;
      wr_data  = wpat(wr_idx);
      pend     = wr_valid && wr_ready;
    end
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [39:0] a, input int na,
                       input int len, input bit wr, input int tlo, input int thi);
    @(negedge clk);
    op_code = op; op_addr = a; op_naddr = 3'(na); op_len = 12'(len);
    op_write = wr; op_t_lo = 4'(tlo); op_t_hi = 4'(thi);
    exp_lo = clampw(tlo); exp_hi = clampw(thi);
    ev_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic verify(input logic [7:0] op, input logic [39:0] a, input int na,
                        input int len, input bit wr, input int wbase, input int rbase,
                        input int dbase);
    automatic int nac = (na > 5) ? 5 : na;
    automatic int nexp = 1 + nac + (wr ? len : 0);
    check(ev_n == nexp, "R5 write-strobe count", ev_n, nexp);
    if (ev_n == nexp) begin
      check(ev_kind[0] == 0 && ev_val[0] == {8'h00, op}, "R2 command cycle", ev_val[0], op);
      for (int i = 0; i < nac; i++) begin
        automatic logic [15:0] e = {8'h00, 8'(a >> (8 * i))};
        check(ev_kind[1+i] == 1, "R3 address levels", ev_kind[1+i], 1);
        check(ev_val[1+i] == e, "R3 R4 address byte", ev_val[1+i], e);
      end
      for (int i = 0; wr && i < len; i++) begin
        check(ev_kind[1+nac+i] == 2 && ev_val[1+nac+i] == wpat(wbase + i),
              "R8 write word", ev_val[1+nac+i], wpat(wbase + i));
      end
    end
    check(rd_got - rbase == (wr ? 0 : len), "R9 read count", rd_got - rbase, wr ? 0 : len);
    check(done_cnt - dbase == 1, "R10 one done", done_cnt - dbase, 1);
    @(negedge clk);
    check(idle && !done && nand_ce_n, "R10 idle after done", {idle, done, nand_ce_n}, 3'b101);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [39:0] a, input int na,
                        input int len, input bit wr, input int tlo, input int thi);
    automatic int wb = wr_idx, rb = rd_got, db = done_cnt;
    bit ok;
    issue(op, a, na, len, wr, tlo, thi);
    wait_done(ok);
    check(ok, "R10 done arrives", ok, 1);
    @(negedge clk);
    verify(op, a, na, len, wr, wb, rb, db);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n && !done, "R1 reset outputs",
          {nand_ce_n, nand_we_n, nand_re_n, done}, 4'b1110);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(idle && nand_ce_n, "R1 idle after reset", {idle, nand_ce_n}, 2'b11);

    // directed: full read, 5 address bytes, LSB first
    run_op(8'h00, 40'h44_33_22_11_00 + 40'h01_01_01_01_01, 5, 4, 0, 3, 2);
    // erase style: 3 address cycles, no data, narrow pulse clamp
    run_op(8'h60, 40'hAB_CD_EF_12_34, 3, 0, 0, 0, 1);
    // clamp of address count (7 -> 5), writes with stream gaps
    run_op(8'h80, 40'h99_88_77_66_55, 7, 6, 1, 1, 0);
    // no address cycles
    run_op(8'h90, 40'h0, 0, 2, 0, 4, 3);

    // R6: busy holds ordinary command
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    begin
      automatic int db = done_cnt, wb = wr_idx, rb0 = rd_got;
      issue(8'h60, 40'h00_00_07_06_05, 3, 0, 0, 2, 2);
      repeat (40) @(negedge clk);
      check(ev_n == 0 && nand_ce_n, "R6 held while busy", ev_n, 0);
      nand_rb_n = 1'b1;
      wait_done(ok);
      check(ok, "R6 proceeds when ready", ok, 1);
      @(negedge clk);
      verify(8'h60, 40'h00_00_07_06_05, 3, 0, 0, wb, rb0, db);
    end
    // R6: status and reset go through while busy
    nand_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    run_op(8'h70, 40'h0, 0, 1, 0, 2, 2);
    run_op(8'hFF, 40'h0, 0, 0, 0, 2, 2);
    nand_rb_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: start during an operation is ignored
    begin
      automatic int db = done_cnt, wb = wr_idx, rb0 = rd_got;
      issue(8'h30, 40'h00_00_00_BB_AA, 2, 1, 0, 2, 2);
      repeat (6) @(negedge clk);
      op_code = 8'h11; op_naddr = 3'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      @(negedge clk);
      verify(8'h30, 40'h00_00_00_BB_AA, 2, 1, 0, wb, rb0, db);
      repeat (20) @(negedge clk);
      check(ev_n == 3 && idle, "R11 no extra cycles", ev_n, 3);
    end

    // constrained random operations
    for (int n = 0; n < 20; n++) begin
      automatic logic [7:0] op = 8'($urandom);
      automatic logic [39:0] a = {8'($urandom), 32'($urandom)};
      run_op(op, a, $urandom % 8, $urandom % 7, 1'($urandom), $urandom % 6, $urandom % 6);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule